// File: doc/BRIEF.md
# Error Interrupt Controller with Severity Routing

This block collects hardware error events from a data compression engine and turns them into interrupts. Each of eleven error sources latches into a sticky source bit. A mask register suppresses chosen sources, and the surviving bits form the status vector. Three per-source enable registers route the status bits to a correctable, a non-fatal and a fatal interrupt line. Software can also inject any error through a set register. This is how a multi-bit ECC fault is forced during bring-up and recovery testing.

A multi-bit ECC error (source bit 1) also captures a diagnostic record: the failing SRAM number and the failing address. The record is taken at the first such error only. If the shutdown enable bit is on when a multi-bit ECC error arrives, the block raises a request that halts outbound bus-master traffic. The request stays up until software turns the enable off.

The register interface is a single-cycle write port with a combinational read, on word addresses: 0x0 source (write 1 to clear), 0x1 mask, 0x2 set (write only), 0x3 masked status (read only), 0x4 correctable enable, 0x5 non-fatal enable, 0x6 fatal enable, 0x7 control, 0x8 ECC record (read only). Any other address reads as zero.

Top module: `err_irq_ctrl`

## Requirements
- R1: After reset, the mask reads 0x7FF. The source, status, the three enables, the control and the ECC record all read 0, and all four outputs are low.
- R2: A 1 on hw_err[i] during a clock edge sets source bit i. The bit stays set until software clears it.
- R3: A write to address 0x0 clears each source bit whose write-data bit is 1. Source bits written with 0 keep their value.
- R4: If a hardware event and a clear hit the same source bit in the same cycle, the bit ends up set.
- R5: A write to address 0x2 sets each source bit whose write-data bit is 1, exactly as a hardware event would. Address 0x2 always reads 0.
- R6: Address 0x3 reads source AND NOT mask in bits 10:0. A mask bit of 1 hides that source.
- R7: irq_ce, irq_nfe and irq_fe are each the OR over all bits of status AND the enable at 0x4, 0x5 or 0x6 respectively.
- R8: On a multi-bit ECC event (hardware or injected on bit 1) while source bit 1 is clear, the ECC record captures ecc_sram_num into bits 23:16 and ecc_sram_addr into bits 31:24. The record then holds unchanged for as long as source bit 1 stays set.
- R9: When control bit 14 is 1, a multi-bit ECC event sets master_halt at the same edge. When control bit 14 is 0, master_halt is never raised. Mask and routing have no effect on master_halt.
- R10: master_halt stays set after the source is cleared. Writing control bit 14 to 0 drops master_halt at that edge. Setting bit 14 again does not re-raise master_halt without a new event.
- R11: The mask and the three enables read back as written in bits 10:0. The control register reads back all 32 bits. Writes to addresses 0x3 and 0x8 change no state.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| hw_err | input | 11 | Error event pulses from the engine, one bit per source |
| ecc_sram_num | input | 8 | SRAM number that goes with a multi-bit ECC event |
| ecc_sram_addr | input | 8 | Failing address that goes with a multi-bit ECC event |
| reg_wr | input | 1 | Register write strobe |
| reg_addr | input | 4 | Register word address |
| reg_wdata | input | 32 | Register write data |
| reg_rdata | output | 32 | Register read data for reg_addr |
| irq_ce | output | 1 | Correctable interrupt |
| irq_nfe | output | 1 | Non-fatal interrupt |
| irq_fe | output | 1 | Fatal interrupt |
| master_halt | output | 1 | Request to halt outbound bus-master traffic |

## Verification
The assertions check on every cycle that events and injections always latch, so set wins over clear. They also check that an interrupt line never rises without an unmasked source, that master_halt never stands while shutdown is disabled, that master_halt only rises after a multi-bit event, and that the ECC record stays frozen while source bit 1 stays set. Other behaviours need scenarios from the bench: the exact values captured in the ECC record, the way routing selects each line, register readback, and the ordering that releases master_halt and then re-arms it. The bench follows the directed sequences with a seeded random mix of events and writes, and compares every output and register against its own reference model.

// File: rtl/err_irq_ctrl.sv
module err_irq_ctrl #(
  parameter int N_SRC  = 11,
  parameter int ADDR_W = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [N_SRC-1:0]  hw_err,
  input  logic [7:0]        ecc_sram_num,
  input  logic [7:0]        ecc_sram_addr,
  input  logic              reg_wr,
  input  logic [ADDR_W-1:0] reg_addr,
  input  logic [31:0]       reg_wdata,
  output logic [31:0]       reg_rdata,
  output logic              irq_ce,
  output logic              irq_nfe,
  output logic              irq_fe,
  output logic              master_halt
);
  localparam int MBIT = 1;
  localparam int SHUT = 14;
  localparam logic [ADDR_W-1:0] A_SRC  = ADDR_W'(0);
  localparam logic [ADDR_W-1:0] A_MASK = ADDR_W'(1);
  localparam logic [ADDR_W-1:0] A_SET  = ADDR_W'(2);
  localparam logic [ADDR_W-1:0] A_STAT = ADDR_W'(3);
  localparam logic [ADDR_W-1:0] A_CE   = ADDR_W'(4);
  localparam logic [ADDR_W-1:0] A_NFE  = ADDR_W'(5);
  localparam logic [ADDR_W-1:0] A_FE   = ADDR_W'(6);
  localparam logic [ADDR_W-1:0] A_CTRL = ADDR_W'(7);
  localparam logic [ADDR_W-1:0] A_ECC  = ADDR_W'(8);

  logic [N_SRC-1:0] src_q, mask_q, ce_q, nfe_q, fe_q;
  logic [31:0]      ctrl_q;
  logic [15:0]      ecc_info_q;
  logic             halt_q;

  logic [N_SRC-1:0] set_v, clr_v, status;
  logic [31:0]      ctrl_d;
  logic             m_event;

  assign set_v   = (reg_wr && reg_addr == A_SET) ? reg_wdata[N_SRC-1:0] : '0;
  assign clr_v   = (reg_wr && reg_addr == A_SRC) ? reg_wdata[N_SRC-1:0] : '0;
  assign ctrl_d  = (reg_wr && reg_addr == A_CTRL) ? reg_wdata : ctrl_q;
  assign m_event = hw_err[MBIT] | set_v[MBIT];
  assign status  = src_q & ~mask_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      src_q      <= '0;
      mask_q     <= '1;
      ce_q       <= '0;
      nfe_q      <= '0;
      fe_q       <= '0;
      ctrl_q     <= '0;
      ecc_info_q <= '0;
      halt_q     <= 1'b0;
    end else begin
      src_q  <= (src_q & ~clr_v) | hw_err | set_v;
      ctrl_q <= ctrl_d;
      halt_q <= ctrl_d[SHUT] & (halt_q | m_event);
      if (m_event && !src_q[MBIT])
        ecc_info_q <= {ecc_sram_addr, ecc_sram_num};
      if (reg_wr) begin
        case (reg_addr)
          A_MASK:  mask_q <= reg_wdata[N_SRC-1:0];
          A_CE:    ce_q   <= reg_wdata[N_SRC-1:0];
          A_NFE:   nfe_q  <= reg_wdata[N_SRC-1:0];
          A_FE:    fe_q   <= reg_wdata[N_SRC-1:0];
          default: ;
        endcase
      end
    end
  end

  always_comb begin
    case (reg_addr)
      A_SRC:   reg_rdata = 32'(src_q);
      A_MASK:  reg_rdata = 32'(mask_q);
      A_STAT:  reg_rdata = 32'(status);
      A_CE:    reg_rdata = 32'(ce_q);
      A_NFE:   reg_rdata = 32'(nfe_q);
      A_FE:    reg_rdata = 32'(fe_q);
      A_CTRL:  reg_rdata = ctrl_q;
      A_ECC:   reg_rdata = {ecc_info_q, 16'h0000};
      default: reg_rdata = '0;
    endcase
  end

  assign irq_ce      = |(status & ce_q);
  assign irq_nfe     = |(status & nfe_q);
  assign irq_fe      = |(status & fe_q);
  assign master_halt = halt_q;
endmodule

// File: rtl/err_irq_chk.sv
module err_irq_chk #(
  parameter int N_SRC = 11
) (
  input logic             clk,
  input logic             rst_n,
  input logic [N_SRC-1:0] hw_err,
  input logic [N_SRC-1:0] set_v,
  input logic [N_SRC-1:0] src_q,
  input logic [N_SRC-1:0] mask_q,
  input logic [15:0]      ecc_info_q,
  input logic             shut_en,
  input logic             irq_ce,
  input logic             irq_nfe,
  input logic             irq_fe,
  input logic             master_halt
);
  AST_EVENT_LATCHES: assert property (@(posedge clk) disable iff (!rst_n)
    (|(hw_err | set_v)) |=> ((src_q & $past(hw_err | set_v)) == $past(hw_err | set_v))); // R4

  AST_IRQ_NEEDS_STATUS: assert property (@(posedge clk) disable iff (!rst_n)
    (irq_ce || irq_nfe || irq_fe) |-> (|(src_q & ~mask_q))); // R7

  AST_HALT_NEEDS_EN: assert property (@(posedge clk) disable iff (!rst_n)
    master_halt |-> shut_en); // R10

  AST_HALT_CAUSE: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(master_halt) |-> $past(hw_err[1] | set_v[1])); // R9

  AST_ECC_FROZEN: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(src_q[1]) && src_q[1]) |-> $stable(ecc_info_q)); // R8
endmodule

bind err_irq_ctrl err_irq_chk #(.N_SRC(N_SRC)) u_chk (
  .clk(clk), .rst_n(rst_n), .hw_err(hw_err), .set_v(set_v),
  .src_q(src_q), .mask_q(mask_q), .ecc_info_q(ecc_info_q),
  .shut_en(ctrl_q[14]), .irq_ce(irq_ce), .irq_nfe(irq_nfe),
  .irq_fe(irq_fe), .master_halt(master_halt)
);

// File: tb/sim_err_irq_ctrl.sv
`timescale 1ns/1ps
module sim_err_irq_ctrl;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [10:0] hw_err = '0;
  logic [7:0]  ecc_sram_num = '0, ecc_sram_addr = '0;
  logic        reg_wr = 1'b0;
  logic [3:0]  reg_addr = '0;
  logic [31:0] reg_wdata = '0;
  logic [31:0] reg_rdata;
  logic        irq_ce, irq_nfe, irq_fe, master_halt;

  int checks = 0, fails = 0;

  logic [10:0] m_src = '0, m_mask = '1, m_ce = '0, m_nfe = '0, m_fe = '0;
  logic [31:0] m_ctrl = '0, m_info = '0;
  logic        m_halt = 1'b0;

  err_irq_ctrl u0 (.*);

  always #5 clk = ~clk;

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual 0x%08h expected 0x%08h", tag, act, exp);
    end
  endtask

  function automatic logic [10:0] exp_status();
    return m_src & ~m_mask;
  endfunction

  task automatic rd(input logic [3:0] a, input logic [31:0] exp, input string tag);
    reg_addr = a;
    #1;
    chk(tag, reg_rdata, exp);
  endtask

  task automatic check_all(input string tag);
    logic [10:0] st;
    st = exp_status();
    chk({tag, " R7 ce"},  32'(irq_ce),  32'(|(st & m_ce)));
    chk({tag, " R7 nfe"}, 32'(irq_nfe), 32'(|(st & m_nfe)));
    chk({tag, " R7 fe"},  32'(irq_fe),  32'(|(st & m_fe)));
    chk({tag, " R9 halt"}, 32'(master_halt), 32'(m_halt));
    rd(4'h0, 32'(m_src),  {tag, " R2 src"});
    rd(4'h1, 32'(m_mask), {tag, " R11 mask"});
    rd(4'h2, 32'h0,       {tag, " R5 set"});
    rd(4'h3, 32'(st),     {tag, " R6 status"});
    rd(4'h4, 32'(m_ce),   {tag, " R11 ce_en"});
    rd(4'h5, 32'(m_nfe),  {tag, " R11 nfe_en"});
    rd(4'h6, 32'(m_fe),   {tag, " R11 fe_en"});
    rd(4'h7, m_ctrl,      {tag, " R11 ctrl"});
    rd(4'h8, m_info,      {tag, " R8 ecc"});
  endtask

  task automatic step(input logic [10:0] hw, input logic we, input logic [3:0] a,
                      input logic [31:0] d, input logic [7:0] num, input logic [7:0] adr);
    logic [10:0] sv, cv;
    logic        mev;
    logic [31:0] cn;
    hw_err = hw; reg_wr = we; reg_addr = a; reg_wdata = d;
    ecc_sram_num = num; ecc_sram_addr = adr;
    @(posedge clk);
    sv  = (we && a == 4'h2) ? d[10:0] : '0;
    cv  = (we && a == 4'h0) ? d[10:0] : '0;
    mev = hw[1] | sv[1];
    if (mev && !m_src[1]) m_info = {adr, num, 16'h0};
    m_src = (m_src & ~cv) | hw | sv;
    cn = (we && a == 4'h7) ? d : m_ctrl;
    m_halt = cn[14] & (m_halt | mev);
    m_ctrl = cn;
    if (we && a == 4'h1) m_mask = d[10:0];
    if (we && a == 4'h4) m_ce   = d[10:0];
    if (we && a == 4'h5) m_nfe  = d[10:0];
    if (we && a == 4'h6) m_fe   = d[10:0];
    @(negedge clk);
    hw_err = '0; reg_wr = 1'b0;
  endtask

  task automatic wr(input logic [3:0] a, input logic [31:0] d);
    step('0, 1'b1, a, d, 8'h00, 8'h00);
  endtask

  task automatic finish_run();
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  endtask

  initial begin
    #2_000_000;
    checks++; fails++;
    $display("FAIL watchdog: actual running expected finished");
    finish_run();
  end

  initial begin
    void'($urandom(32'd20240611));
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    chk("R1 mask", 32'(u0.reg_rdata & 0) | 32'h0, 32'h0);
    rd(4'h1, 32'h7FF, "R1 mask reset");
    check_all("R1 reset");

    wr(4'h1, 32'h0);
    wr(4'h4, 32'h1);
    wr(4'h5, 32'h7FE);
    step(11'h001, 1'b0, 4'h0, 0, 0, 0);
    chk("R7 ce from bit0", 32'(irq_ce), 32'h1);
    chk("R7 nfe quiet", 32'(irq_nfe), 32'h0);
    check_all("R2 bit0");

    wr(4'h1, 32'h1);
    chk("R6 masked ce", 32'(irq_ce), 32'h0);
    rd(4'h3, 32'h0, "R6 status masked");
    wr(4'h1, 32'h0);

    step(11'h020, 1'b0, 4'h0, 0, 0, 0);
    wr(4'h0, 32'h001);
    rd(4'h0, 32'h020, "R3 w1c keeps others");
    step(11'h020, 1'b1, 4'h0, 32'h020, 0, 0);
    rd(4'h0, 32'h020, "R4 set wins");
    wr(4'h0, 32'h7FF);
    rd(4'h0, 32'h0, "R3 clear all");

    step(11'h002, 1'b0, 4'h0, 0, 8'hA5, 8'h3C);
    rd(4'h8, 32'h3CA5_0000, "R8 capture");
    step(11'h002, 1'b0, 4'h0, 0, 8'h77, 8'h88);
    rd(4'h8, 32'h3CA5_0000, "R8 frozen");
    chk("R9 halt off when disabled", 32'(master_halt), 32'h0);
    wr(4'h0, 32'h002);
    step('0, 1'b1, 4'h2, 32'h002, 8'h11, 8'h22);
    rd(4'h8, 32'h2211_0000, "R8 recapture after clear");
    rd(4'h0, 32'h002, "R5 inject bit1");
    rd(4'h2, 32'h0, "R5 set reads zero");
    check_all("R5 inject");

    wr(4'h7, 32'h0000_4000);
    chk("R9 no halt without event", 32'(master_halt), 32'h0);
    wr(4'h1, 32'h7FF);
    step('0, 1'b1, 4'h2, 32'h002, 0, 0);
    chk("R9 halt on inject while masked", 32'(master_halt), 32'h1);
    wr(4'h0, 32'h7FF);
    chk("R10 halt holds after clear", 32'(master_halt), 32'h1);
    wr(4'h7, 32'h0);
    chk("R10 halt released", 32'(master_halt), 32'h0);
    wr(4'h7, 32'h0000_4000);
    chk("R10 no re-raise", 32'(master_halt), 32'h0);
    wr(4'h1, 32'h0);

    wr(4'h6, 32'h400);
    step(11'h400, 1'b0, 4'h0, 0, 0, 0);
    chk("R7 fatal route", 32'(irq_fe), 32'h1);
    wr(4'h3, 32'h0);
    wr(4'h8, 32'hFFFF_FFFF);
    check_all("R11 ro writes ignored");

    for (int i = 0; i < 600; i++) begin
      logic [10:0] hw;
      logic [3:0]  a;
      logic [31:0] d;
      hw = (($urandom % 4) == 0) ? 11'(1 << ($urandom % 11)) : '0;
      a  = 4'($urandom % 10);
      d  = $urandom;
      if (a == 4'h7) d[14] = ($urandom % 3) != 0;
      step(hw, ($urandom % 2) == 1, a, d, 8'($urandom), 8'($urandom));
      chk("R7 rand ce", 32'(irq_ce), 32'(|(exp_status() & m_ce)));
      chk("R9 rand halt", 32'(master_halt), 32'(m_halt));
      if (i % 25 == 0) check_all("rand");
    end
    check_all("final");
    finish_run();
  end
endmodule